// File: doc/BRIEF.md
# Two-Wire EEPROM Write Slave

This block is the write side of a serial EEPROM slave on a two-wire bus. SCL and SDA arrive as plain inputs. SDA is open-drain, so the slave drives it only through a pull-low enable. Both lines are resampled in the system clock domain, where the block detects START and STOP conditions and shifts in bytes.

A write transfer has four parts: a device address with the write direction, a high and a low word-address byte, and then one or more data bytes. The data bytes are collected in a one-page staging buffer. Nothing reaches the array until STOP. At that point a timed internal write cycle copies the staged bytes into their page. For the whole cycle the slave is deaf to the bus. A master can therefore poll with bare address bytes until it gets an acknowledge back.

A write-protect input lets the address phase complete but refuses data. A side-band read port gives direct access to the array for inspection. The word address is 13 bits wide. The array depth is set by a parameter: the default build holds 2048 bytes and ignores the top address bits, and setting `MEM_AW` to 13 gives the full 8192 bytes.

Top module: `eeprom_wr_slave`

## Requirements
- R1: After START, the slave pulls SDA low in the ninth clock of the first byte only if that byte's upper 7 bits equal `DEV_ADDR` (default 7'h50) and its last bit is 0 (write). Any other first byte gets no acknowledge, and the slave ignores the bus until the next START.
- R2: Once the device address is accepted, the slave acknowledges two word-address bytes. The low 5 bits of the first byte become address bits 12..8 and its top 3 bits are discarded. The second byte supplies address bits 7..0.
- R3: Each data byte is acknowledged and staged at the current address. After each byte only the low 5 bits of the address advance, so bytes after offset 31 land at offset 0 of the same 32-byte page.
- R4: When more than 32 data bytes arrive in one transfer, a later byte replaces the earlier byte staged at the same offset. The last value sent to each offset is the one written.
- R5: A STOP that follows at least one accepted data byte commits only the staged offsets to the array. Every other byte of that page keeps its previous contents.
- R6: For `TWR_CYCLES` system clocks after a committing STOP, the slave never pulls SDA low, not even for its own device address. Afterwards it again acknowledges its device address.
- R7: While `wp_i` is high, the device address and both word-address bytes are acknowledged, but the first data byte is not. The following STOP starts no write cycle and leaves the array unchanged.
- R8: A START in the middle of a transfer discards any staged data and restarts the address phase. A STOP with no accepted data byte starts no write cycle.
- R9: After reset, SDA is released, no write cycle is running, and the device address is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND value) |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| wp_i | input | 1 | Write protect, high blocks data acceptance |
| dbg_addr_i | input | MEM_AW | Side-band array read address |
| dbg_data_o | output | 8 | Array byte at `dbg_addr_i` |

## Verification
Four burst shapes are used. A full aligned 32-byte burst gives a known baseline page. A short burst that starts at offset 30 and wraps shows that the pointer stays inside its page and that untouched bytes keep their values. A 34-byte burst, addressed with junk in the top bits of the high byte, separates the overwrite rule from the page-wrap rule and shows those top bits are dropped. The remaining transfers each change the array in none of the legal ways: a protected write, a write aborted by a repeated START, and an address-only write. For each one, an immediate poll is acknowledged, which proves no write cycle started, whereas a poll right after a real commit is refused until `TWR_CYCLES` have passed.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK
  } link_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } byte_phase_e;
endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;
  logic       scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s      = scl_ff[1];
  assign sda_s_o    = sda_ff[1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/eeprom_wr_fsm.sv
module eeprom_wr_fsm
  import eeprom_wr_pkg::*;
#(
  parameter int          ADDR_W   = 13,
  parameter int          PAGE_W   = 5,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     sda_i,
  input  logic                     busy_i,
  input  logic                     wp_i,
  input  logic                     any_valid_i,
  output logic                     sda_pull_o,
  output logic                     buf_we_o,
  output logic [PAGE_W-1:0]        buf_off_o,
  output logic [7:0]               buf_data_o,
  output logic                     buf_clr_o,
  output logic                     commit_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o
);
  link_state_e       state_q, state_n;
  byte_phase_e       phase_q, phase_n;
  logic [3:0]        bitcnt_q, bitcnt_n;
  logic [7:0]        shreg_q, shreg_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              pull_q, pull_n;
  logic              ack;

  always_comb begin
    state_n   = state_q;
    phase_n   = phase_q;
    bitcnt_n  = bitcnt_q;
    shreg_n   = shreg_q;
    addr_n    = addr_q;
    pull_n    = pull_q;
    ack       = 1'b0;
    buf_we_o  = 1'b0;
    buf_clr_o = 1'b0;
    commit_o  = 1'b0;
    if (busy_i) begin
      state_n = ST_IDLE;
      pull_n  = 1'b0;
    end else if (start_i) begin
      state_n   = ST_RX;
      phase_n   = PH_DEV;
      bitcnt_n  = 4'd0;
      pull_n    = 1'b0;
      buf_clr_o = 1'b1;
    end else if (stop_i) begin
      state_n = ST_IDLE;
      pull_n  = 1'b0;
      if (any_valid_i && !wp_i) commit_o  = 1'b1;
      else                      buf_clr_o = 1'b1;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            shreg_n  = {shreg_q[6:0], sda_i};
            bitcnt_n = bitcnt_q + 4'd1;
          end else if (scl_fall_i && bitcnt_q == 4'd8) begin
            case (phase_q)
              PH_DEV:  ack = (shreg_q[7:1] == DEV_ADDR) && !shreg_q[0];
              PH_AHI: begin
                ack = 1'b1;
                addr_n[ADDR_W-1:8] = shreg_q[ADDR_W-9:0];
              end
              PH_ALO: begin
                ack = 1'b1;
                addr_n[7:0] = shreg_q;
              end
              default: begin
                ack = !wp_i;
                if (!wp_i) begin
                  buf_we_o = 1'b1;
                  addr_n[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + 1'b1;
                end
              end
            endcase
            if (ack) begin
              state_n = ST_ACK;
              pull_n  = 1'b1;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            pull_n   = 1'b0;
            state_n  = ST_RX;
            bitcnt_n = 4'd0;
            case (phase_q)
              PH_DEV:  phase_n = PH_AHI;
              PH_AHI:  phase_n = PH_ALO;
              default: phase_n = PH_DATA;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_DEV;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      addr_q   <= '0;
      pull_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      phase_q  <= phase_n;
      bitcnt_q <= bitcnt_n;
      shreg_q  <= shreg_n;
      addr_q   <= addr_n;
      pull_q   <= pull_n;
    end
  end

  assign sda_pull_o = pull_q;
  assign buf_off_o  = addr_q[PAGE_W-1:0];
  assign buf_data_o = shreg_q;
  assign page_o     = addr_q[ADDR_W-1:PAGE_W];

  AST_DEV_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && $past(state_q) == ST_RX && phase_q == PH_DEV) |-> !$past(shreg_q[0])); // R1

  AST_WP_DATA_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && $past(state_q) == ST_RX && phase_q == PH_DATA) |-> !$past(wp_i)); // R7

  AST_PTR_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |=> (addr_q[PAGE_W-1:0] == PAGE_W'($past(addr_q[PAGE_W-1:0]) + 1'b1))
                 && (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]))); // R3
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_W = 5,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [PAGE_W-1:0]     wr_off_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  clr_i,
  input  logic [PAGE_W-1:0]     rd_off_i,
  output logic [7:0]            rd_data_o,
  output logic                  rd_valid_o,
  output logic                  any_valid_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q, valid_n;

  always_comb begin
    valid_n = valid_q;
    if (clr_i)     valid_n = '0;
    else if (we_i) valid_n[wr_off_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_n;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && wr_off_i == PAGE_W'(g)) data_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o   = data_q[rd_off_i];
  assign rd_valid_o  = valid_q[rd_off_i];
  assign any_valid_o = |valid_q;
endmodule

// File: rtl/eeprom_commit.sv
module eeprom_commit #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_W     = 5,
  parameter int MEM_AW     = 11,
  parameter int TWR_CYCLES = 400,
  localparam int CNT_W     = $clog2(TWR_CYCLES + 1),
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     go_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic                     slot_valid_i,
  output logic [PAGE_W-1:0]        slot_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     mem_we_o,
  output logic [MEM_AW-1:0]        mem_addr_o
);
  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [ADDR_W-1:0] full_addr;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    done_o = 1'b0;
    if (!busy_q) begin
      if (go_i) begin
        busy_n = 1'b1;
        cnt_n  = '0;
      end
    end else if (cnt_q == CNT_W'(TWR_CYCLES - 1)) begin
      busy_n = 1'b0;
      done_o = 1'b1;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign slot_o     = cnt_q[PAGE_W-1:0];
  assign full_addr  = {page_i, slot_o};
  assign mem_addr_o = full_addr[MEM_AW-1:0];
  assign mem_we_o   = busy_q && (cnt_q < CNT_W'(PAGE_BYTES)) && slot_valid_i;
  assign busy_o     = busy_q;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int MEM_AW = 11,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave #(
  parameter int         ADDR_W     = 13,
  parameter int         PAGE_W     = 5,
  parameter int         MEM_AW     = 11,
  parameter int         TWR_CYCLES = 400,
  parameter logic [6:0] DEV_ADDR   = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              wp_i,
  input  logic [MEM_AW-1:0] dbg_addr_i,
  output logic [7:0]        dbg_data_o
);
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, done, commit_go, any_valid;
  logic buf_we, fsm_clr, slot_valid, mem_we;
  logic [PAGE_W-1:0] buf_off, slot;
  logic [7:0] buf_data, slot_data;
  logic [ADDR_W-PAGE_W-1:0] page;
  logic [MEM_AW-1:0] mem_addr;

  eeprom_line_sync i_sync (
    .clk_i(clk_i), .rst_ni(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  eeprom_wr_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_ADDR(DEV_ADDR)) i_fsm (
    .clk_i(clk_i), .rst_ni(rst_s), .start_i(start_det), .stop_i(stop_det),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .busy_i(busy), .wp_i(wp_i), .any_valid_i(any_valid),
    .sda_pull_o(sda_pull_o), .buf_we_o(buf_we), .buf_off_o(buf_off),
    .buf_data_o(buf_data), .buf_clr_o(fsm_clr), .commit_o(commit_go),
    .page_o(page)
  );

  eeprom_page_buf #(.PAGE_W(PAGE_W)) i_buf (
    .clk_i(clk_i), .rst_ni(rst_s), .we_i(buf_we), .wr_off_i(buf_off),
    .wr_data_i(buf_data), .clr_i(fsm_clr | done), .rd_off_i(slot),
    .rd_data_o(slot_data), .rd_valid_o(slot_valid), .any_valid_o(any_valid)
  );

  eeprom_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MEM_AW(MEM_AW),
                  .TWR_CYCLES(TWR_CYCLES)) i_commit (
    .clk_i(clk_i), .rst_ni(rst_s), .go_i(commit_go), .page_i(page),
    .slot_valid_i(slot_valid), .slot_o(slot), .busy_o(busy), .done_o(done),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr)
  );

  eeprom_array #(.MEM_AW(MEM_AW)) i_array (
    .clk_i(clk_i), .we_i(mem_we), .waddr_i(mem_addr), .wdata_i(slot_data),
    .raddr_i(dbg_addr_i), .rdata_o(dbg_data_o)
  );

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_s)
    busy |-> !sda_pull_o); // R6

  AST_BUF_FROZEN_IN_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_s)
    mem_we |-> !buf_we); // R5

  AST_BUF_EMPTY_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_s)
    $fell(busy) |=> !any_valid); // R5

  AST_NO_COMMIT_UNDER_WP: assert property (@(posedge clk_i) disable iff (!rst_s)
    $rose(busy) |-> !$past(wp_i)); // R7
endmodule

// File: tb/test_eeprom_wr_slave.sv
module test_eeprom_wr_slave;
  localparam int MEM_AW = 11;
  localparam int TWR    = 400;
  localparam int Q      = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic [MEM_AW-1:0] dbg_addr = '0;
  logic [7:0] dbg_data;
  logic sda_pull;
  logic sda_line;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  eeprom_wr_slave #(.MEM_AW(MEM_AW), .TWR_CYCLES(TWR)) i_eeprom_wr_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .wp_i(wp), .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data)
  );

  typedef struct { string tag; logic [7:0] exp; } item_t;
  item_t exp_q[$];
  logic [7:0] obs;
  event ev_obs;
  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [0:(1<<MEM_AW)-1];

  always begin
    @(ev_obs);
    if (exp_q.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL unexpected result: actual %0h expected none", obs);
    end else begin
      item_t it;
      it = exp_q.pop_front();
      n_cmp++;
      if (obs !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, obs, it.exp);
      end
    end
  end

  task automatic report(string tag, logic [7:0] exp, logic [7:0] got);
    exp_q.push_back('{tag, exp});
    obs = got;
    -> ev_obs;
    #1;
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q); scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q); scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(2*Q);
  endtask

  task automatic send_byte(logic [7:0] b, logic exp_ack, string tag);
    logic got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(Q); scl_m = 1'b1; waitc(2*Q); scl_m = 1'b0; waitc(Q);
    end
    sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
    got = sda_pull;
    waitc(Q); scl_m = 1'b0; waitc(Q);
    report(tag, {7'd0, exp_ack}, {7'd0, got});
  endtask

  task automatic poll(logic exp_ack, string tag);
    bus_start();
    send_byte(8'hA0, exp_ack, tag);
    bus_stop();
  endtask

  // Burst write; the model applies the page-wrap rule only when data is accepted
  task automatic burst(logic [7:0] hi, logic [7:0] lo, int n, logic [7:0] seed, string tag);
    logic [12:0] a;
    logic [7:0] d;
    a = {hi[4:0], lo};
    bus_start();
    send_byte(8'hA0, 1'b1, "R1");
    send_byte(hi, 1'b1, "R2");
    send_byte(lo, 1'b1, "R2");
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 7);
      send_byte(d, !wp, wp ? "R7" : tag);
      if (wp) break;
      model[MEM_AW'({a[12:5], 5'(a[4:0] + 5'(k))})] = d;
    end
    bus_stop();
  endtask

  task automatic check_page(logic [MEM_AW-1:0] base, string tag);
    for (int i = 0; i < 32; i++) begin
      dbg_addr = base + MEM_AW'(i);
      waitc(1);
      report(tag, model[base + MEM_AW'(i)], dbg_data);
    end
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL pending: actual %0d items left expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    // R9: released after reset, address acknowledged immediately
    report("R9", 8'h00, {7'd0, sda_pull});
    poll(1'b1, "R9");

    // Full aligned page at 0x100; poll refused during the write cycle (R6)
    burst(8'h01, 8'h00, 32, 8'h5A, "R3");
    poll(1'b0, "R6");
    waitc(TWR);
    poll(1'b1, "R6");
    check_page(MEM_AW'(13'h100), "R5");

    // Short burst from offset 30 wraps to offsets 0,1; rest of page unchanged
    burst(8'h01, 8'h1E, 4, 8'hC3, "R3");
    waitc(TWR + 50);
    check_page(MEM_AW'(13'h100), "R3");

    // 34 bytes from offset 5 with junk top bits in high byte: overwrite of 5,6
    burst(8'hE2, 8'h05, 34, 8'h11, "R4");
    waitc(TWR + 50);
    check_page(MEM_AW'(13'h200), "R4");

    // Wrong device address and read direction are refused
    bus_start(); send_byte(8'hA2, 1'b0, "R1"); bus_stop();
    bus_start(); send_byte(8'hA1, 1'b0, "R1"); bus_stop();
    poll(1'b1, "R1");

    // Write protect: data refused, no write cycle
    wp = 1'b1;
    burst(8'h01, 8'h00, 3, 8'h77, "R7");
    wp = 1'b0;
    poll(1'b1, "R7");
    check_page(MEM_AW'(13'h100), "R7");

    // Repeated START aborts staged data
    bus_start();
    send_byte(8'hA0, 1'b1, "R8");
    send_byte(8'h01, 1'b1, "R8");
    send_byte(8'h00, 1'b1, "R8");
    send_byte(8'hEE, 1'b1, "R8");
    bus_start();
    send_byte(8'hA0, 1'b1, "R8");
    bus_stop();
    poll(1'b1, "R8");

    // Address-only transfer starts no write cycle
    burst(8'h02, 8'h00, 0, 8'h00, "R8");
    poll(1'b1, "R8");
    check_page(MEM_AW'(13'h100), "R8");
    check_page(MEM_AW'(13'h200), "R8");

    finish_run();
  end
endmodule